// File: doc/BRIEF.md
# Seven-Product 2x2 Signed Matrix Multiplier

This block multiplies two 2x2 matrices of signed integers using the seven-product decomposition. It does not use the usual eight products. A start pulse loads both operands in parallel, as eight quarter entries. One shared multiplier then works through the seven products, one per clock. Each product feeds up to two of four result accumulators, with the sign fixed by a small table. When the last product has been folded in, the four results are copied to the output registers and a single-cycle done pulse is raised.

The seven products are formed from sums and differences of the quarter entries:
- P1 = (a11+a22)(b11+b22)
- P2 = (a21+a22)·b11
- P3 = a11·(b12−b22)
- P4 = a22·(b21−b11)
- P5 = (a11+a12)·b22
- P6 = (a21−a11)(b11+b12)
- P7 = (a12−a22)(b21+b22)

The results are built only from these products:
- c11 = P1+P4−P5+P7
- c12 = P3+P5
- c21 = P2+P4
- c22 = P1−P2+P3+P6

Ten pre-adds and eight post-adds make eighteen additions or subtractions in total.

The controller has four states:
- IDLE waits for start and moves to MULT when start is seen.
- MULT issues one product index per cycle. After the seventh index it moves to DRAIN.
- DRAIN lets the last registered product reach the accumulators, then moves to PUBLISH.
- PUBLISH copies the accumulators to the outputs, raises done and returns to IDLE.

Top module: `strassen_mm2x2`

## Requirements
- R1: After reset, done is 0 and all four result outputs are 0.
- R2: A start sampled high in IDLE latches all eight operand entries at that clock edge. Later changes on the operand inputs do not affect that computation.
- R3: The shared multiplier produces exactly seven products, one per cycle, in order P1 to P7, on seven consecutive clock edges.
- R4: After done, c11 = a11·b11+a12·b21, c12 = a11·b12+a12·b22, c21 = a21·b11+a22·b21 and c22 = a21·b12+a22·b22. The results are exact, for any operands.
- R5: Operands are 16-bit two's complement and results are 36-bit two's complement. No overflow occurs, including for operands at −32768 and 32767.
- R6: done is high for exactly one cycle. It rises on the 9th clock edge after the edge that accepted start.
- R7: A start sampled while the block is not in IDLE is ignored. This includes the PUBLISH cycle. No extra done is produced, and the results belong to the accepted operands.
- R8: The result outputs change only on the edge that raises done. They hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only in IDLE |
| a11 | input | 16 | Operand A, row 1 column 1 |
| a12 | input | 16 | Operand A, row 1 column 2 |
| a21 | input | 16 | Operand A, row 2 column 1 |
| a22 | input | 16 | Operand A, row 2 column 2 |
| b11 | input | 16 | Operand B, row 1 column 1 |
| b12 | input | 16 | Operand B, row 1 column 2 |
| b21 | input | 16 | Operand B, row 2 column 1 |
| b22 | input | 16 | Operand B, row 2 column 2 |
| done | output | 1 | One-cycle pulse when results are updated |
| c11 | output | 36 | Result, row 1 column 1 |
| c12 | output | 36 | Result, row 1 column 2 |
| c21 | output | 36 | Result, row 2 column 1 |
| c22 | output | 36 | Result, row 2 column 2 |

## Verification
The assertions assume that start is a synchronous level, sampled only at clock edges, and that reset is applied before the first start. They place no limit on operand values, because the operands are latched at acceptance. The bench drives every input on the falling edge, so start is always sampled cleanly. It also deliberately raises start while the block is busy and changes the operands after acceptance, to exercise the ignore and latch behaviour. Random operands come from a fixed seed and are mixed with all-minimum, all-maximum and mixed-sign corner matrices.

// File: rtl/strassen_pkg.sv
package strassen_pkg;
    localparam int NPROD = 7;
    localparam int NOUT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MULT,
        ST_DRAIN,
        ST_PUBLISH
    } mm_state_t;

    // Contribution of product p (0..6 => P1..P7) to output o (0..3 => c11,c12,c21,c22)
    // +1 add, -1 subtract, 0 none
    function automatic int contrib(input int p, input int o);
        int r;
        r = 0;
        unique case (p)
            0: r = (o == 0 || o == 3) ? 1 : 0;
            1: r = (o == 2) ? 1 : ((o == 3) ? -1 : 0);
            2: r = (o == 1 || o == 3) ? 1 : 0;
            3: r = (o == 0 || o == 2) ? 1 : 0;
            4: r = (o == 0) ? -1 : ((o == 1) ? 1 : 0);
            5: r = (o == 3) ? 1 : 0;
            6: r = (o == 0) ? 1 : 0;
            default: r = 0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/strassen_preadd.sv
module strassen_preadd #(
    parameter int DATA_W = 16,
    parameter int STEP_W = 3,
    localparam int SUM_W = DATA_W + 1
) (
    input  logic [STEP_W-1:0]       step_i,
    input  logic signed [DATA_W-1:0] a11_i,
    input  logic signed [DATA_W-1:0] a12_i,
    input  logic signed [DATA_W-1:0] a21_i,
    input  logic signed [DATA_W-1:0] a22_i,
    input  logic signed [DATA_W-1:0] b11_i,
    input  logic signed [DATA_W-1:0] b12_i,
    input  logic signed [DATA_W-1:0] b21_i,
    input  logic signed [DATA_W-1:0] b22_i,
    output logic signed [SUM_W-1:0]  lhs_o,
    output logic signed [SUM_W-1:0]  rhs_o
);
    logic signed [SUM_W-1:0] xa11, xa12, xa21, xa22, xb11, xb12, xb21, xb22;

    assign xa11 = {a11_i[DATA_W-1], a11_i};
    assign xa12 = {a12_i[DATA_W-1], a12_i};
    assign xa21 = {a21_i[DATA_W-1], a21_i};
    assign xa22 = {a22_i[DATA_W-1], a22_i};
    assign xb11 = {b11_i[DATA_W-1], b11_i};
    assign xb12 = {b12_i[DATA_W-1], b12_i};
    assign xb21 = {b21_i[DATA_W-1], b21_i};
    assign xb22 = {b22_i[DATA_W-1], b22_i};

    always_comb begin
        lhs_o = '0;
        rhs_o = '0;
        unique case (step_i)
            STEP_W'(0): begin lhs_o = xa11 + xa22; rhs_o = xb11 + xb22; end
            STEP_W'(1): begin lhs_o = xa21 + xa22; rhs_o = xb11;        end
            STEP_W'(2): begin lhs_o = xa11;        rhs_o = xb12 - xb22; end
            STEP_W'(3): begin lhs_o = xa22;        rhs_o = xb21 - xb11; end
            STEP_W'(4): begin lhs_o = xa11 + xa12; rhs_o = xb22;        end
            STEP_W'(5): begin lhs_o = xa21 - xa11; rhs_o = xb11 + xb12; end
            STEP_W'(6): begin lhs_o = xa12 - xa22; rhs_o = xb21 + xb22; end
            default:    begin lhs_o = '0;          rhs_o = '0;          end
        endcase
    end
endmodule

// File: rtl/strassen_mul_unit.sv
module strassen_mul_unit #(
    parameter int SUM_W  = 17,
    parameter int STEP_W = 3,
    parameter int NPROD  = 7,
    localparam int PROD_W = 2 * SUM_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld_i,
    input  logic [STEP_W-1:0]        idx_i,
    input  logic signed [SUM_W-1:0]  lhs_i,
    input  logic signed [SUM_W-1:0]  rhs_i,
    output logic                     vld_o,
    output logic [STEP_W-1:0]        idx_o,
    output logic signed [PROD_W-1:0] prod_o
);
    logic signed [PROD_W-1:0] lhs_x, rhs_x;

    assign lhs_x = {{SUM_W{lhs_i[SUM_W-1]}}, lhs_i};
    assign rhs_x = {{SUM_W{rhs_i[SUM_W-1]}}, rhs_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            idx_o  <= '0;
            prod_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                idx_o  <= idx_i;
                prod_o <= lhs_x * rhs_x;
            end
        end
    end

    AST_PROD_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && idx_o != STEP_W'(NPROD-1)) |=> (vld_o && idx_o == $past(idx_o) + STEP_W'(1))); // R3
    AST_PROD_STARTS_P1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vld_o)) |-> (idx_o == '0)); // R3
endmodule

// File: rtl/strassen_combine.sv
module strassen_combine #(
    parameter int PROD_W = 34,
    parameter int STEP_W = 3,
    localparam int RES_W = PROD_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     vld_i,
    input  logic [STEP_W-1:0]        idx_i,
    input  logic signed [PROD_W-1:0] prod_i,
    output logic signed [RES_W-1:0]  acc_o [strassen_pkg::NOUT]
);
    import strassen_pkg::*;

    logic signed [RES_W-1:0] prod_x;
    assign prod_x = {{2{prod_i[PROD_W-1]}}, prod_i};

    for (genvar o = 0; o < NOUT; o++) begin : g_acc
        logic [NPROD-1:0] add_map, sub_map;
        for (genvar p = 0; p < NPROD; p++) begin : g_map
            assign add_map[p] = (contrib(p, o) > 0);
            assign sub_map[p] = (contrib(p, o) < 0);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_o[o] <= '0;
            end else if (clr_i) begin
                acc_o[o] <= '0;
            end else if (vld_i) begin
                if (add_map[idx_i])
                    acc_o[o] <= acc_o[o] + prod_x;
                else if (sub_map[idx_i])
                    acc_o[o] <= acc_o[o] - prod_x;
            end
        end
    end
endmodule

// File: rtl/strassen_mm2x2.sv
module strassen_mm2x2 #(
    parameter int DATA_W = 16,
    localparam int SUM_W  = DATA_W + 1,
    localparam int PROD_W = 2 * SUM_W,
    localparam int RES_W  = PROD_W + 2,
    localparam int STEP_W = $clog2(strassen_pkg::NPROD)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] a11,
    input  logic signed [DATA_W-1:0] a12,
    input  logic signed [DATA_W-1:0] a21,
    input  logic signed [DATA_W-1:0] a22,
    input  logic signed [DATA_W-1:0] b11,
    input  logic signed [DATA_W-1:0] b12,
    input  logic signed [DATA_W-1:0] b21,
    input  logic signed [DATA_W-1:0] b22,
    output logic                     done,
    output logic signed [RES_W-1:0]  c11,
    output logic signed [RES_W-1:0]  c12,
    output logic signed [RES_W-1:0]  c21,
    output logic signed [RES_W-1:0]  c22
);
    import strassen_pkg::*;

    localparam int LAT = 9;

    mm_state_t state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic accept;

    logic signed [DATA_W-1:0] ra11, ra12, ra21, ra22, rb11, rb12, rb21, rb22;
    logic signed [SUM_W-1:0]  lhs, rhs;
    logic                     p_vld;
    logic [STEP_W-1:0]        p_idx;
    logic signed [PROD_W-1:0] p_val;
    logic signed [RES_W-1:0]  acc [NOUT];

    assign accept = (state_q == ST_IDLE) && start;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_MULT;
            ST_MULT:    if (step_q == STEP_W'(NPROD-1)) state_d = ST_DRAIN;
            ST_DRAIN:   state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_MULT)
                step_q <= step_q + STEP_W'(1);
            else
                step_q <= '0;
        end
    end

    // output and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            c11 <= '0; c12 <= '0; c21 <= '0; c22 <= '0;
            ra11 <= '0; ra12 <= '0; ra21 <= '0; ra22 <= '0;
            rb11 <= '0; rb12 <= '0; rb21 <= '0; rb22 <= '0;
        end else begin
            done <= (state_q == ST_PUBLISH);
            if (accept) begin
                ra11 <= a11; ra12 <= a12; ra21 <= a21; ra22 <= a22;
                rb11 <= b11; rb12 <= b12; rb21 <= b21; rb22 <= b22;
            end
            if (state_q == ST_PUBLISH) begin
                c11 <= acc[0]; c12 <= acc[1]; c21 <= acc[2]; c22 <= acc[3];
            end
        end
    end

    strassen_preadd #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_preadd (
        .step_i(step_q),
        .a11_i(ra11), .a12_i(ra12), .a21_i(ra21), .a22_i(ra22),
        .b11_i(rb11), .b12_i(rb12), .b21_i(rb21), .b22_i(rb22),
        .lhs_o(lhs), .rhs_o(rhs)
    );

    strassen_mul_unit #(.SUM_W(SUM_W), .STEP_W(STEP_W), .NPROD(NPROD)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .vld_i(state_q == ST_MULT), .idx_i(step_q),
        .lhs_i(lhs), .rhs_i(rhs),
        .vld_o(p_vld), .idx_o(p_idx), .prod_o(p_val)
    );

    strassen_combine #(.PROD_W(PROD_W), .STEP_W(STEP_W)) u_comb (
        .clk(clk), .rst_n(rst_n),
        .clr_i(accept), .vld_i(p_vld), .idx_i(p_idx), .prod_i(p_val),
        .acc_o(acc)
    );

    // latency window counter for the checks below
    logic [3:0] since_acc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          since_acc <= 4'hF;
        else if (accept)     since_acc <= '0;
        else if (since_acc != 4'hF) since_acc <= since_acc + 4'd1;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_acc == 4'(LAT))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(ra11) && $stable(rb22) && $stable(ra21) && $stable(rb12))); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(c11) && $stable(c12) && $stable(c21) && $stable(c22))); // R8
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MULT) |-> (step_q <= STEP_W'(NPROD-1))); // R3
endmodule

// File: tb/strassen_mm2x2_tb_top.sv
`timescale 1ns/1ps
module strassen_mm2x2_tb_top;
    localparam int DW = 16;
    localparam int RW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [DW-1:0] a11 = '0, a12 = '0, a21 = '0, a22 = '0;
    logic signed [DW-1:0] b11 = '0, b12 = '0, b21 = '0, b22 = '0;
    logic done;
    logic signed [RW-1:0] c11, c12, c21, c22;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    strassen_mm2x2 #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a11(a11), .a12(a12), .a21(a21), .a22(a22),
        .b11(b11), .b12(b12), .b21(b21), .b22(b22),
        .done(done), .c11(c11), .c12(c12), .c21(c21), .c22(c22)
    );

    function automatic longint ref_c(input int r, input int c,
        input longint x11, input longint x12, input longint x21, input longint x22,
        input longint y11, input longint y12, input longint y21, input longint y22);
        longint xr0, xr1, yc0, yc1;
        xr0 = (r == 0) ? x11 : x21;
        xr1 = (r == 0) ? x12 : x22;
        yc0 = (c == 0) ? y11 : y12;
        yc1 = (c == 0) ? y21 : y22;
        return xr0 * yc0 + xr1 * yc1;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_ops(input int v[8]);
        a11 = DW'(v[0]); a12 = DW'(v[1]); a21 = DW'(v[2]); a22 = DW'(v[3]);
        b11 = DW'(v[4]); b12 = DW'(v[5]); b21 = DW'(v[6]); b22 = DW'(v[7]);
    endtask

    task automatic check_results(input string req, input int v[8]);
        check(req, "c11", longint'(c11), ref_c(0,0,v[0],v[1],v[2],v[3],v[4],v[5],v[6],v[7]));
        check(req, "c12", longint'(c12), ref_c(0,1,v[0],v[1],v[2],v[3],v[4],v[5],v[6],v[7]));
        check(req, "c21", longint'(c21), ref_c(1,0,v[0],v[1],v[2],v[3],v[4],v[5],v[6],v[7]));
        check(req, "c22", longint'(c22), ref_c(1,1,v[0],v[1],v[2],v[3],v[4],v[5],v[6],v[7]));
    endtask

    // Runs one computation; optional busy-start injection at cycle inj (0 = none).
    task automatic run(input string req, input int v[8], input int inj, input int w[8]);
        int first_done;
        int done_cnt;
        first_done = 0;
        done_cnt = 0;
        @(negedge clk);
        set_ops(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        set_ops(w);                       // R2: inputs change after acceptance
        for (int k = 1; k <= 14; k++) begin
            if (k == inj) start = 1'b1;   // R7: start while busy
            if (k == inj + 1) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (done) begin
                done_cnt++;
                if (first_done == 0) begin
                    first_done = k;
                    check_results(req, v);
                end
            end
            if (k == 9 && inj == 9) start = 1'b0;
        end
        start = 1'b0;
        check("R6", "done edge index", first_done, 9);
        check("R6", "done pulse count", done_cnt, 1);
    endtask

    initial begin
        int v[8];
        int w[8];
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 8; i++) w[i] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "done after reset", longint'(done), 0);
        check("R1", "c11 after reset", longint'(c11), 0);
        check("R1", "c22 after reset", longint'(c22), 0);
        rst_n = 1'b1;

        // directed: simple values
        v = '{1, 2, 3, 4, 5, 6, 7, 8};
        run("R4", v, 0, w);

        // extremes, R5
        v = '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768};
        run("R5", v, 0, w);
        v = '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767};
        run("R5", v, 0, w);
        v = '{-32768, 32767, 32767, -32768, 32767, -32768, -32768, 32767};
        run("R5", v, 0, w);
        v = '{32767, -32768, -32768, 32767, -32768, -32768, 32767, 32767};
        run("R5", v, 0, w);

        // R2: operand inputs change right after acceptance
        v = '{-7, 11, 300, -2, 9, -1000, 4, 25};
        for (int i = 0; i < 8; i++) w[i] = 12345 - i * 777;
        run("R2", v, 0, w);

        // R7: busy start at cycles 3 and 9 (PUBLISH) ignored
        v = '{100, -200, 300, -400, 500, -600, 700, -800};
        run("R7", v, 3, w);
        v = '{-1, -1, -1, -1, 2, 2, 2, 2};
        run("R7", v, 9, w);

        // R8: results held after done while inputs change
        set_ops(w);
        repeat (5) @(negedge clk);
        check_results("R8", v);
        check("R8", "no done while idle", longint'(done), 0);

        // R3/R4: random operands
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 8; i++) v[i] = int'($signed(16'($urandom())));
            for (int i = 0; i < 8; i++) w[i] = int'($signed(16'($urandom())));
            run("R4", v, 0, w);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule